// File: doc/BRIEF.md
# Parallel Flash Word Fetch Engine

This block reads one word of 1, 2 or 4 bytes from an external parallel Flash or EEPROM on behalf of a boot loader. The caller presents a byte address, a word-size code and a bus-width flag. The block then runs as many external read cycles as the word needs. For each read it drives the memory chip select, output enable and a 20-bit address. The bytes that come back are packed into a 32-bit result, right-aligned and zero-extended, and a one-cycle done pulse marks the result as valid.

The external device may be wired with 8 data pins or with 16. In 16-bit mode the pins carry a halfword address, and the lane on pins 15:8 holds the byte at the lower address. Bytes are assembled big-endian, so the byte at the lowest address becomes the most significant byte of the result. The block never writes: the write strobe and the second chip select stay inactive.

Top module: `pflash_word_fetch`

## Requirements
- R1: `req_size` selects the word: 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes. When `done` is high, `rdata` holds the word right-aligned, with every bit above the word cleared.
- R2: With `req_wide` = 0, only `mem_din[7:0]` is used. The block makes one read per byte, at byte addresses base, base+1, and so on.
- R3: With `req_wide` = 1, read k drives the halfword address (base >> 1) + k. The number of reads is the byte count divided by two, with a minimum of one. Address bit 0 is ignored for 2- and 4-byte words.
- R4: The result is big-endian. On a 16-bit bus, `mem_din[15:8]` is the lower-addressed byte and `mem_din[7:0]` is the next byte.
- R5: A 1-byte word on a 16-bit bus takes `mem_din[15:8]` when address bit 0 is 0, and `mem_din[7:0]` when it is 1.
- R6: In each read, `mem_cs1_n` and `mem_oe_n` are low together for exactly WAIT_CYC cycles (default 4), with `mem_addr` stable throughout. Data is sampled in the last low cycle. The strobes then go high for one cycle.
- R7: `done` is high for one cycle, N·(WAIT_CYC+1) cycles after the accepting edge, where N is the number of reads. `busy` is low in the following cycle.
- R8: A request is accepted only when `busy` is low. A request raised while busy is ignored, including one raised in the cycle of `done`.
- R9: `mem_cs2_n` and `mem_we_n` are high at all times, including during reset.
- R10: After reset, `busy` = 0, `done` = 0, `mem_cs1_n` = `mem_oe_n` = 1 and `rdata` = 0.
- R11: Byte and halfword addresses wrap modulo the 20-bit space.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe, taken when busy is low |
| req_addr | input | 20 | Byte address of the word |
| req_size | input | 2 | Word size code |
| req_wide | input | 1 | 1 = 16-bit data bus, 0 = 8-bit |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle result-valid pulse |
| rdata | output | 32 | Assembled word |
| mem_addr | output | 20 | External address pins |
| mem_din | input | 16 | External data pins |
| mem_cs1_n | output | 1 | Memory chip select, active low |
| mem_cs2_n | output | 1 | Second chip select, held high |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, held high |

## Verification
The two events that can share a cycle are the completion pulse and a new request. The bench raises `req_valid` in exactly the cycle in which `done` is high, and also once in the middle of a transfer. In both cases it judges from the pins: the result must match the first request, `busy` must drop the next cycle, and no further chip-select activity or `done` may appear for several read periods. The rest of the bench is an arithmetic sweep over all sizes, both bus widths and edge addresses. It includes addresses that wrap at the top of the 20-bit space.

// File: rtl/pfw_pkg.sv
package pfw_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_ACC  = 2'd1,
      ST_GAP  = 2'd2
   } pfw_state_e;

   // index of the final bus read for a word size / bus width pair
   function automatic logic [1:0] last_read_idx(input logic [1:0] size, input logic wide);
      logic [1:0] r;
      if (wide) r = (size >= 2'd2) ? 2'd1 : 2'd0;
      else      r = (size == 2'd0) ? 2'd0 : ((size == 2'd1) ? 2'd1 : 2'd3);
      return r;
   endfunction

endpackage

// File: rtl/pfw_seq.sv
module pfw_seq
   import pfw_pkg::*;
#(
   parameter int WAIT_CYC = 4,
   parameter int IDX_W    = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [IDX_W-1:0] last_idx_in,
   output pfw_state_e       state,
   output logic [IDX_W-1:0] rd_idx,
   output logic             sample,
   output logic             fin
);

   localparam int WCNT_W = (WAIT_CYC > 1) ? $clog2(WAIT_CYC) : 1;
   localparam logic [WCNT_W-1:0] WCNT_END = WCNT_W'(WAIT_CYC - 1);

   logic [WCNT_W-1:0] wcnt;
   logic [IDX_W-1:0]  last_idx;

   assign sample = (state == ST_ACC) && (wcnt == WCNT_END);
   assign fin    = (state == ST_GAP) && (rd_idx == last_idx);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         wcnt     <= '0;
         rd_idx   <= '0;
         last_idx <= '0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (start) begin
                  state    <= ST_ACC;
                  wcnt     <= '0;
                  rd_idx   <= '0;
                  last_idx <= last_idx_in;
               end
            end
            ST_ACC: begin
               if (wcnt == WCNT_END) state <= ST_GAP;
               else                  wcnt  <= wcnt + 1'b1;
            end
            ST_GAP: begin
               wcnt <= '0;
               if (fin) begin
                  state <= ST_IDLE;
               end else begin
                  rd_idx <= rd_idx + 1'b1;
                  state  <= ST_ACC;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/pfw_addr_gen.sv
module pfw_addr_gen #(
   parameter int ADDR_W = 20,
   parameter int IDX_W  = 2
) (
   input  logic [ADDR_W-1:0] base,
   input  logic              wide,
   input  logic [IDX_W-1:0]  idx,
   output logic [ADDR_W-1:0] addr
);

   logic [ADDR_W-2:0] half_addr;
   logic [ADDR_W-1:0] byte_addr;

   // halfword pointer wraps in ADDR_W-1 bits, byte pointer in ADDR_W bits
   assign half_addr = base[ADDR_W-1:1] + (ADDR_W-1)'(idx);
   assign byte_addr = base + ADDR_W'(idx);
   assign addr      = wide ? {1'b0, half_addr} : byte_addr;

endmodule

// File: rtl/pfw_pack.sv
module pfw_pack #(
   parameter int DATA_W = 16,
   parameter int WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              sample,
   input  logic              wide,
   input  logic              one_byte,
   input  logic              lane_lo,
   input  logic [DATA_W-1:0] din,
   output logic [WORD_W-1:0] acc
);

   localparam int NLANES = DATA_W / 8;

   logic [7:0] lanes [NLANES];
   logic [7:0] byte_sel;

   for (genvar g = 0; g < NLANES; g++) begin : g_lane
      assign lanes[g] = din[g*8 +: 8];
   end

   // top lane carries the lower-addressed byte on a wide bus
   assign byte_sel = (wide && !lane_lo) ? lanes[NLANES-1] : lanes[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc <= '0;
      end else if (clear) begin
         acc <= '0;
      end else if (sample) begin
         if (wide && !one_byte) acc <= {acc[WORD_W-DATA_W-1:0], din};
         else                   acc <= {acc[WORD_W-9:0], byte_sel};
      end
   end

endmodule

// File: rtl/pflash_word_fetch.sv
module pflash_word_fetch
   import pfw_pkg::*;
#(
   parameter int ADDR_W   = 20,
   parameter int DATA_W   = 16,
   parameter int WORD_W   = 32,
   parameter int WAIT_CYC = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [1:0]        req_size,
   input  logic              req_wide,
   output logic              busy,
   output logic              done,
   output logic [WORD_W-1:0] rdata,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic [DATA_W-1:0] mem_din,
   output logic              mem_cs1_n,
   output logic              mem_cs2_n,
   output logic              mem_oe_n,
   output logic              mem_we_n
);

   localparam int IDX_W = 2;

   if (DATA_W != 16) begin : g_bad_data
      $error("pflash_word_fetch: DATA_W must be 16");
   end
   if (WORD_W != 32) begin : g_bad_word
      $error("pflash_word_fetch: WORD_W must be 32");
   end
   if (WAIT_CYC < 1) begin : g_bad_wait
      $error("pflash_word_fetch: WAIT_CYC must be at least 1");
   end
   if (ADDR_W < 2) begin : g_bad_addr
      $error("pflash_word_fetch: ADDR_W too small");
   end

   pfw_state_e        state;
   logic [IDX_W-1:0]  rd_idx;
   logic              sample;
   logic              fin;
   logic              start;
   logic [ADDR_W-1:0] base_q;
   logic              wide_q;
   logic              one_q;

   assign start = req_valid && (state == ST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         wide_q <= 1'b0;
         one_q  <= 1'b0;
      end else if (start) begin
         base_q <= req_addr;
         wide_q <= req_wide;
         one_q  <= (req_size == 2'd0);
      end
   end

   pfw_seq #(
      .WAIT_CYC (WAIT_CYC),
      .IDX_W    (IDX_W)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .last_idx_in (last_read_idx(req_size, req_wide)),
      .state       (state),
      .rd_idx      (rd_idx),
      .sample      (sample),
      .fin         (fin)
   );

   pfw_addr_gen #(
      .ADDR_W (ADDR_W),
      .IDX_W  (IDX_W)
   ) u_addr (
      .base (base_q),
      .wide (wide_q),
      .idx  (rd_idx),
      .addr (mem_addr)
   );

   pfw_pack #(
      .DATA_W (DATA_W),
      .WORD_W (WORD_W)
   ) u_pack (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (start),
      .sample   (sample),
      .wide     (wide_q),
      .one_byte (one_q),
      .lane_lo  (base_q[0]),
      .din      (mem_din),
      .acc      (rdata)
   );

   assign busy      = (state != ST_IDLE);
   assign done      = fin;
   assign mem_cs1_n = (state != ST_ACC);
   assign mem_oe_n  = (state != ST_ACC);
   assign mem_cs2_n = 1'b1;
   assign mem_we_n  = 1'b1;

endmodule

// File: rtl/pflash_word_fetch_chk.sv
module pflash_word_fetch_chk #(
   parameter int ADDR_W   = 20,
   parameter int WAIT_CYC = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              busy,
   input logic              done,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_cs1_n,
   input logic              mem_cs2_n,
   input logic              mem_oe_n,
   input logic              mem_we_n
);

   localparam int LCNT_W = $clog2(WAIT_CYC + 2);

   logic [LCNT_W-1:0] low_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         low_cnt <= '0;
      else if (!mem_oe_n) low_cnt <= low_cnt + 1'b1;
      else                low_cnt <= '0;
   end

   // R9
   cs2_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n) mem_cs2_n && mem_we_n);

   // R6
   strobe_pair_chk: assert property (@(posedge clk) disable iff (!rst_n) mem_cs1_n == mem_oe_n);

   // R6
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_cs1_n && $past(!mem_cs1_n)) |-> $stable(mem_addr));

   // R6
   wait_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_oe_n) |-> (low_cnt == LCNT_W'(WAIT_CYC)));

   // R6
   wait_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      low_cnt <= LCNT_W'(WAIT_CYC));

   // R7
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);

   // R7
   done_release_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !busy);

   // R6
   done_gap_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> mem_cs1_n);

   // R8
   accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !busy) |=> busy);

   // R8
   no_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> busy);

endmodule

bind pflash_word_fetch pflash_word_fetch_chk #(
   .ADDR_W   (ADDR_W),
   .WAIT_CYC (WAIT_CYC)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .busy      (busy),
   .done      (done),
   .mem_addr  (mem_addr),
   .mem_cs1_n (mem_cs1_n),
   .mem_cs2_n (mem_cs2_n),
   .mem_oe_n  (mem_oe_n),
   .mem_we_n  (mem_we_n)
);

// File: tb/pflash_word_fetch_tb.sv
module pflash_word_fetch_tb;

   localparam int W = 4;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        req_valid;
   logic [19:0] req_addr;
   logic [1:0]  req_size;
   logic        req_wide;
   logic        busy, done;
   logic [31:0] rdata;
   logic [19:0] mem_addr;
   logic [15:0] mem_din;
   logic        mem_cs1_n, mem_cs2_n, mem_oe_n, mem_we_n;
   logic        cur_wide;

   int nchk  = 0;
   int nfail = 0;
   int r9_bad = 0;

   always #2 clk = ~clk;

   pflash_word_fetch #(.WAIT_CYC(W)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .req_size(req_size), .req_wide(req_wide), .busy(busy), .done(done),
      .rdata(rdata), .mem_addr(mem_addr), .mem_din(mem_din),
      .mem_cs1_n(mem_cs1_n), .mem_cs2_n(mem_cs2_n), .mem_oe_n(mem_oe_n),
      .mem_we_n(mem_we_n)
   );

   function automatic logic [7:0] mbyte(input logic [19:0] a);
      logic [7:0] t;
      t = a[7:0] * 8'd29;
      return t ^ a[15:8] ^ {4'h0, a[19:16]} ^ 8'h5C;
   endfunction

   // memory model: 16-bit device returns even byte on the upper lane
   always_comb begin
      if (mem_oe_n)      mem_din = 16'hDEAD;
      else if (cur_wide) mem_din = {mbyte({mem_addr[18:0], 1'b0}), mbyte({mem_addr[18:0], 1'b1})};
      else               mem_din = {8'hC3, mbyte(mem_addr)};
   end

   always @(negedge clk) if (mem_cs2_n !== 1'b1 || mem_we_n !== 1'b1) r9_bad++;

   function automatic int nbytes(input logic [1:0] s);
      return (s == 2'd0) ? 1 : ((s == 2'd1) ? 2 : 4);
   endfunction

   function automatic int nreads(input logic [1:0] s, input logic w);
      int b = nbytes(s);
      return w ? ((b > 1) ? b / 2 : 1) : b;
   endfunction

   function automatic logic [31:0] exp_val(input logic [19:0] a, input logic [1:0] s, input logic w);
      logic [31:0] v = '0;
      int b = nbytes(s);
      logic [19:0] base = (w && b > 1) ? {a[19:1], 1'b0} : a;
      for (int i = 0; i < b; i++) v = (v << 8) | {24'h0, mbyte(base + 20'(i))};
      return v;
   endfunction

   function automatic logic [19:0] exp_addr(input logic [19:0] a, input logic w, input int k);
      logic [18:0] h = a[19:1] + 19'(k);
      return w ? {1'b0, h} : a + 20'(k);
   endfunction

   task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s act=%h exp=%h", what, act, exp);
      end
   endtask

   // inject: 0 none, 1 extra request while busy, 2 extra request in the done cycle
   task automatic xfer(input logic [19:0] a, input logic [1:0] s, input logic w,
                       input int inject, input string tag);
      int cyc, reads, oecnt, done_cyc, n;
      bit prev_cs, addr_ok, quiet;
      logic [31:0] got;
      n = nreads(s, w);
      @(negedge clk);
      req_valid = 1'b1; req_addr = a; req_size = s; req_wide = w; cur_wide = w;
      @(negedge clk);
      req_valid = 1'b0;
      cyc = 1; reads = 0; oecnt = 0; done_cyc = 0; prev_cs = 1'b1; addr_ok = 1'b1; got = '0;
      while (cyc < 100) begin
         if (!mem_cs1_n && prev_cs) begin
            if (mem_addr !== exp_addr(a, w, reads)) addr_ok = 1'b0;
            reads++;
         end
         if (!mem_oe_n) oecnt++;
         prev_cs = mem_cs1_n;
         req_valid = (inject == 1 && cyc == 2) || (inject == 2 && done === 1'b1);
         req_addr  = a ^ 20'h0F0F3;
         if (done === 1'b1) begin
            done_cyc = cyc;
            got = rdata;
            break;
         end
         @(negedge clk);
         req_valid = 1'b0;
         cyc++;
      end
      chk(got === exp_val(a, s, w), $sformatf("R1 R4 %s value a=%h s=%0d w=%0d", tag, a, s, w),
          got, exp_val(a, s, w));
      chk(reads == n && addr_ok, $sformatf("R2 R3 %s read sequence a=%h s=%0d w=%0d", tag, a, s, w),
          32'(reads), 32'(n));
      chk(oecnt == n * W, $sformatf("R6 strobe cycles a=%h s=%0d w=%0d", a, s, w),
          32'(oecnt), 32'(n * W));
      chk(done_cyc == n * (W + 1), $sformatf("R7 done timing a=%h s=%0d w=%0d", a, s, w),
          32'(done_cyc), 32'(n * (W + 1)));
      @(negedge clk);
      req_valid = 1'b0;
      chk(busy === 1'b0 && done === 1'b0, "R7 release after done", {30'h0, busy, done}, 32'h0);
      if (inject != 0) begin
         quiet = 1'b1;
         for (int i = 0; i < 3 * (W + 1); i++) begin
            if (mem_cs1_n !== 1'b1 || done !== 1'b0 || busy !== 1'b0) quiet = 1'b0;
            @(negedge clk);
         end
         chk(quiet, $sformatf("R8 ignored request inject=%0d", inject), {31'h0, quiet}, 32'h1);
      end
   endtask

   initial begin
      #(4 * 200000);
      nchk++;
      nfail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   end

   initial begin
      logic [19:0] addrs [8];
      addrs[0] = 20'h00000; addrs[1] = 20'h00001; addrs[2] = 20'h00002; addrs[3] = 20'h12345;
      addrs[4] = 20'h80001; addrs[5] = 20'hFFFFE; addrs[6] = 20'hFFFFF; addrs[7] = 20'h5A5A3;
      rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_size = '0; req_wide = 1'b0; cur_wide = 1'b0;
      repeat (3) @(negedge clk);
      // R10 reset state
      chk(busy === 1'b0 && done === 1'b0 && mem_cs1_n === 1'b1 && mem_oe_n === 1'b1,
          "R10 reset controls", {28'h0, busy, done, mem_cs1_n, mem_oe_n}, 32'h3);
      chk(rdata === 32'h0, "R10 reset rdata", rdata, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int w = 0; w < 2; w++)
         for (int s = 0; s < 4; s++)
            for (int k = 0; k < 8; k++)
               xfer(addrs[k], 2'(s), w[0], 0, (w == 1 && s == 0) ? "R5" : "sweep");

      // R11 wrap at the top of the byte and halfword spaces
      xfer(20'hFFFFE, 2'd2, 1'b0, 0, "R11 narrow wrap");
      xfer(20'hFFFFF, 2'd2, 1'b1, 0, "R11 wide wrap");
      // R5 lane choice by address bit 0
      xfer(20'h00ABC, 2'd0, 1'b1, 0, "R5 upper lane");
      xfer(20'h00ABD, 2'd0, 1'b1, 0, "R5 lower lane");
      // R8 request while busy, and a request coinciding with done
      xfer(20'h00310, 2'd2, 1'b0, 1, "R8 mid");
      xfer(20'h00311, 2'd1, 1'b1, 2, "R8 at done");
      xfer(20'h00400, 2'd2, 1'b1, 2, "R8 at done wide");

      // R9 second select and write strobe never active
      chk(r9_bad == 0, "R9 cs2/we held high", 32'(r9_bad), 32'h0);

      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   end

endmodule